// File: doc/BRIEF.md
# Ring Descriptor Engine

This block serves one channel of a copy accelerator that software drives through two rings in local memory. Software builds 32-byte job entries in a submission ring and advances a tail pointer. The engine follows with its own head pointer. It fetches each new entry and decodes its opcode. For a copy job it presents the length, source and destination to an external data mover and waits for a done strobe. It then writes a 16-byte result entry into a completion ring and, if the job asked for it, pulses an interrupt.

Both rings share one programmable depth, given as depth minus one, and both pointers wrap at that depth. Each result entry carries a phase-coded valid bit. Software can therefore tell fresh entries from stale ones without clearing the ring. The engine does not overwrite a result that software has not yet consumed: it waits while the completion ring is full. Memory is reached through a single word-wide port with a read latency of one cycle. All addresses are 32-bit word addresses.

Top module: `ring_desc_engine`

## Requirements
- R1: While reset is asserted and just after it, both ring pointers read 0 and `irq_o`, `copy_req_o` and `mem_req_o` are low.
- R2: While `sq_tail_i` equals the internal submission head, the engine issues no memory request and no copy request.
- R3: For each pending entry, the engine reads the eight words at `sq_base_i + head*8`. Word 0 bits [3:0] hold the opcode and bit 8 is the interrupt enable. Word 3 is the byte length. Words 4 and 5 are the source address (low word, then high word). Words 6 and 7 are the destination address (low word, then high word). All other bits are ignored.
- R4: Opcode 4 raises `copy_req_o` with the length, source and destination. These values stay stable until `copy_done_i` is sampled high. The completion status is then 0.
- R5: Opcode 1 completes with status 0 and raises no copy request.
- R6: Any other opcode completes with status `ERR_STATUS` (default 1) and raises no copy request.
- R7: A completion is four words written in order at `cq_base_i + tail*4`. Words 0 and 1 are zero. Word 2 holds the advanced submission head in bits [15:0], with the upper half zero. Word 3 has bits [15:0] zero, the valid bit at bit 16 and the status in bits [31:17].
- R8: The valid bit equals a phase flag. The flag is 1 after reset and inverts each time the completion tail wraps to 0.
- R9: Both the submission head and the completion tail step by one per entry and return to 0 after reaching `depth_m1_i`.
- R10: No completion word is written while the completion tail plus one, modulo the depth, equals `cq_head_i`. Posting resumes once software moves its head.
- R11: When the entry's bit 8 is set, `irq_o` pulses high for exactly one cycle, in the cycle after the last completion word is written. When bit 8 is clear, `irq_o` stays low.
- R12: Entries are handled strictly one at a time and in ring order. `sq_head_o` advances only while an entry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_m1_i | input | IDX_W | Ring depth minus one |
| sq_base_i | input | ADDR_W | Submission ring base (word address) |
| cq_base_i | input | ADDR_W | Completion ring base (word address) |
| sq_tail_i | input | IDX_W | Software submission tail doorbell |
| cq_head_i | input | IDX_W | Software completion head |
| sq_head_o | output | IDX_W | Engine submission head |
| cq_tail_o | output | IDX_W | Engine completion tail |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |
| copy_req_o | output | 1 | Copy job request to the data mover |
| copy_len_o | output | 32 | Copy length in bytes |
| copy_src_o | output | 64 | Copy source address |
| copy_dst_o | output | 64 | Copy destination address |
| copy_done_i | input | 1 | Data mover finished the job |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The engine is driven with single jobs and with bursts of five entries queued behind one doorbell. Each job mixes copy, small-package and unknown opcodes with the interrupt flag set or clear. This separates the status coding and the copy-request gating per opcode, and it shows whether the entries are kept in order. A depth-four run fills the completion ring until it is full and stalls it, then releases the stall by moving the software head. This run also wraps both rings, which exposes a wrong full test, wrong pointer wrap or missed phase inversion. A depth-eight run after a reset repeats the wrap at another depth, so that a hard-coded depth stands out.

// File: rtl/ring_desc_pkg.sv
package ring_desc_pkg;
    localparam int SQE_WORDS = 8;
    localparam int CQE_WORDS = 4;
    localparam int STAT_W    = 15;
    localparam logic [3:0] OPC_COPY  = 4'h4;
    localparam logic [3:0] OPC_SMALL = 4'h1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_EXEC,
        ST_COPY,
        ST_POST
    } eng_state_e;
endpackage

// File: rtl/ring_step.sv
module ring_step #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] cur_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] nxt_o,
    output logic             wrap_o
);
    assign wrap_o = (cur_i == last_i);
    assign nxt_o  = wrap_o ? '0 : cur_i + 1'b1;
endmodule

// File: rtl/sqe_classify.sv
module sqe_classify
    import ring_desc_pkg::*;
#(
    parameter logic [STAT_W-1:0] ERR_STATUS = 15'h0001
) (
    input  logic [3:0]        opcode_i,
    output logic              is_copy_o,
    output logic [STAT_W-1:0] status_o
);
    logic is_small;

    always_comb begin
        is_copy_o = (opcode_i == OPC_COPY);
        is_small  = (opcode_i == OPC_SMALL);
        status_o  = (is_copy_o || is_small) ? '0 : ERR_STATUS;
    end
endmodule

// File: rtl/cqe_format.sv
module cqe_format
    import ring_desc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [1:0]        sel_i,
    input  logic [IDX_W-1:0]  head_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic              valid_i,
    output logic [31:0]       word_o
);
    always_comb begin
        case (sel_i)
            2'd2:    word_o = {16'h0000, 16'(head_i)};
            2'd3:    word_o = {status_i, valid_i, 16'h0000};
            default: word_o = 32'h0;
        endcase
    end
endmodule

// File: rtl/ring_desc_engine.sv
module ring_desc_engine
    import ring_desc_pkg::*;
#(
    parameter int                IDX_W      = 4,
    parameter int                ADDR_W     = 16,
    parameter logic [STAT_W-1:0] ERR_STATUS = 15'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  depth_m1_i,
    input  logic [ADDR_W-1:0] sq_base_i,
    input  logic [ADDR_W-1:0] cq_base_i,
    input  logic [IDX_W-1:0]  sq_tail_i,
    input  logic [IDX_W-1:0]  cq_head_i,
    output logic [IDX_W-1:0]  sq_head_o,
    output logic [IDX_W-1:0]  cq_tail_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              copy_req_o,
    output logic [31:0]       copy_len_o,
    output logic [63:0]       copy_src_o,
    output logic [63:0]       copy_dst_o,
    input  logic              copy_done_i,
    output logic              irq_o
);
    localparam int SQE_SHIFT = $clog2(SQE_WORDS);
    localparam int CQE_SHIFT = $clog2(CQE_WORDS);
    localparam int CNT_W     = SQE_SHIFT;
    localparam logic [CNT_W-1:0] SQE_LAST = CNT_W'(SQE_WORDS - 1);
    localparam logic [1:0]       CQE_LAST = 2'(CQE_WORDS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              rd_pend;
        logic [CNT_W-1:0]  rd_idx;
        logic [3:0]        opcode;
        logic              ien;
        logic [31:0]       len;
        logic [63:0]       src;
        logic [63:0]       dst;
        logic [IDX_W-1:0]  sq_head;
        logic [IDX_W-1:0]  cq_tail;
        logic              phase;
        logic [STAT_W-1:0] status;
        logic              irq;
    } eng_t;

    eng_t q, d;

    logic [IDX_W-1:0]  sq_nxt, cq_nxt;
    logic              sq_wrap, cq_wrap;
    logic              is_copy;
    logic [STAT_W-1:0] cls_status;
    logic [31:0]       cqe_word;
    logic [ADDR_W-1:0] sq_addr, cq_addr;
    logic              cq_full;

    ring_step #(.IDX_W(IDX_W)) u_sq_step (
        .cur_i (q.sq_head),
        .last_i(depth_m1_i),
        .nxt_o (sq_nxt),
        .wrap_o(sq_wrap)
    );

    ring_step #(.IDX_W(IDX_W)) u_cq_step (
        .cur_i (q.cq_tail),
        .last_i(depth_m1_i),
        .nxt_o (cq_nxt),
        .wrap_o(cq_wrap)
    );

    sqe_classify #(.ERR_STATUS(ERR_STATUS)) u_classify (
        .opcode_i (q.opcode),
        .is_copy_o(is_copy),
        .status_o (cls_status)
    );

    cqe_format #(.IDX_W(IDX_W)) u_format (
        .sel_i   (q.cnt[1:0]),
        .head_i  (q.sq_head),
        .status_i(q.status),
        .valid_i (q.phase),
        .word_o  (cqe_word)
    );

    assign sq_addr = sq_base_i + (ADDR_W'(q.sq_head) << SQE_SHIFT) + ADDR_W'(q.cnt);
    assign cq_addr = cq_base_i + (ADDR_W'(q.cq_tail) << CQE_SHIFT) + ADDR_W'(q.cnt[1:0]);
    assign cq_full = (cq_nxt == cq_head_i);

    always_comb begin
        d           = q;
        d.irq       = 1'b0;
        d.rd_pend   = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sq_addr;
        mem_wdata_o = cqe_word;
        copy_req_o  = 1'b0;

        // capture the word requested in the previous cycle
        if (q.rd_pend) begin
            case (q.rd_idx)
                CNT_W'(0): begin
                    d.opcode = mem_rdata_i[3:0];
                    d.ien    = mem_rdata_i[8];
                end
                CNT_W'(3): d.len        = mem_rdata_i;
                CNT_W'(4): d.src[31:0]  = mem_rdata_i;
                CNT_W'(5): d.src[63:32] = mem_rdata_i;
                CNT_W'(6): d.dst[31:0]  = mem_rdata_i;
                CNT_W'(7): d.dst[63:32] = mem_rdata_i;
                default: ;
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (sq_tail_i != q.sq_head) begin
                    d.st  = ST_FETCH;
                    d.cnt = '0;
                end
            end
            ST_FETCH: begin
                mem_req_o = 1'b1;
                d.rd_pend = 1'b1;
                d.rd_idx  = q.cnt;
                if (q.cnt == SQE_LAST) begin
                    d.st = ST_DRAIN;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                d.status  = cls_status;
                d.sq_head = sq_nxt;
                d.cnt     = '0;
                d.st      = is_copy ? ST_COPY : ST_POST;
            end
            ST_COPY: begin
                copy_req_o = 1'b1;
                if (copy_done_i) begin
                    d.st  = ST_POST;
                    d.cnt = '0;
                end
            end
            ST_POST: begin
                mem_addr_o = cq_addr;
                if (!cq_full) begin
                    mem_req_o = 1'b1;
                    mem_we_o  = 1'b1;
                    if (q.cnt[1:0] == CQE_LAST) begin
                        d.cq_tail = cq_nxt;
                        if (cq_wrap) begin
                            d.phase = ~q.phase;
                        end
                        d.irq = q.ien;
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.phase <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sq_head_o  = q.sq_head;
    assign cq_tail_o  = q.cq_tail;
    assign copy_len_o = q.len;
    assign copy_src_o = q.src;
    assign copy_dst_o = q.dst;
    assign irq_o      = q.irq;

    logic unused_sq_wrap;
    assign unused_sq_wrap = sq_wrap;
endmodule

// File: rtl/ring_desc_engine_chk.sv
module ring_desc_engine_chk #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  depth_m1_i,
    input logic [ADDR_W-1:0] sq_base_i,
    input logic [IDX_W-1:0]  sq_tail_i,
    input logic [IDX_W-1:0]  cq_head_i,
    input logic [IDX_W-1:0]  sq_head_o,
    input logic [IDX_W-1:0]  cq_tail_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              copy_req_o,
    input logic [31:0]       copy_len_o,
    input logic [63:0]       copy_src_o,
    input logic [63:0]       copy_dst_o,
    input logic              copy_done_i,
    input logic              irq_o
);
    logic [IDX_W-1:0] tail_step;
    always_comb tail_step = (cq_tail_o == depth_m1_i) ? '0 : cq_tail_o + 1'b1;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!mem_req_o && !copy_req_o && !irq_o));

    // R10
    no_post_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (tail_step != cq_head_i));

    // R11
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_req_o && mem_we_o));

    // R4
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req_o && !copy_done_i) |=> (copy_req_o && $stable(copy_len_o)
                                          && $stable(copy_src_o) && $stable(copy_dst_o)));

    // R12
    head_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_head_o != $past(sq_head_o)) |-> $past(sq_head_o != sq_tail_i));

    // R12
    one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(copy_req_o && mem_req_o));

    // R3
    read_in_sq_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> (mem_addr_o >= sq_base_i));
endmodule

bind ring_desc_engine ring_desc_engine_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth_m1_i (depth_m1_i),
    .sq_base_i  (sq_base_i),
    .sq_tail_i  (sq_tail_i),
    .cq_head_i  (cq_head_i),
    .sq_head_o  (sq_head_o),
    .cq_tail_o  (cq_tail_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .copy_req_o (copy_req_o),
    .copy_len_o (copy_len_o),
    .copy_src_o (copy_src_o),
    .copy_dst_o (copy_dst_o),
    .copy_done_i(copy_done_i),
    .irq_o      (irq_o)
);

// File: tb/ring_desc_engine_bench.sv
module ring_desc_engine_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int IDX_W  = 4;
    localparam int ADDR_W = 16;
    localparam int SQB    = 0;
    localparam int CQB    = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [IDX_W-1:0]  depth_m1, sq_tail, cq_head, sq_head, cq_tail;
    logic              mem_req, mem_we, copy_req, copy_done, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata, copy_len;
    logic [63:0]       copy_src, copy_dst;

    always #2.5 clk = ~clk;

    ring_desc_engine #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ring_desc_engine (
        .clk(clk), .rst_n(rst_n), .depth_m1_i(depth_m1),
        .sq_base_i(ADDR_W'(SQB)), .cq_base_i(ADDR_W'(CQB)),
        .sq_tail_i(sq_tail), .cq_head_i(cq_head),
        .sq_head_o(sq_head), .cq_tail_o(cq_tail),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .copy_req_o(copy_req), .copy_len_o(copy_len), .copy_src_o(copy_src),
        .copy_dst_o(copy_dst), .copy_done_i(copy_done), .irq_o(irq)
    );

    logic [31:0] mem [0:127];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[6:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[6:0]];
    end

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int depth, sw_tail, sw_cqh, m_cqt, wr_cnt;
    bit m_phase, irq_next;
    int          q_slot[$], q_sqslot[$];
    logic [31:0] q_w2[$], q_w3[$];
    bit          q_irq[$];
    logic [31:0] qc_len[$];
    logic [63:0] qc_src[$], qc_dst[$];

    task automatic model_reset(input int dep);
        depth = dep; sw_tail = 0; sw_cqh = 0; m_cqt = 0; m_phase = 1'b1; irq_next = 1'b0;
        q_slot.delete(); q_sqslot.delete(); q_w2.delete(); q_w3.delete(); q_irq.delete();
        qc_len.delete(); qc_src.delete(); qc_dst.delete();
        depth_m1 = IDX_W'(dep - 1); sq_tail = '0; cq_head = '0;
    endtask

    task automatic submit(input logic [3:0] op, input bit ien, input logic [31:0] len,
                          input logic [63:0] src, input logic [63:0] dst);
        int base;
        logic [31:0] w0;
        logic [14:0] st;
        base = SQB + sw_tail * 8;
        w0 = 32'hA5A5_0000;
        w0[3:0] = op; w0[8] = ien; w0[14:12] = 3'b101;
        mem[base+0] <= w0;
        mem[base+1] <= 32'hDEAD_0001;
        mem[base+2] <= 32'h0300_0000;
        mem[base+3] <= len;
        mem[base+4] <= src[31:0];
        mem[base+5] <= src[63:32];
        mem[base+6] <= dst[31:0];
        mem[base+7] <= dst[63:32];
        q_sqslot.push_back(sw_tail);
        sw_tail = (sw_tail + 1) % depth;
        st = (op == 4'h4 || op == 4'h1) ? 15'h0 : 15'h1;
        q_slot.push_back(m_cqt);
        q_w2.push_back({16'h0, 16'(sw_tail)});
        q_w3.push_back({st, m_phase, 16'h0});
        q_irq.push_back(ien);
        if (op == 4'h4) begin
            qc_len.push_back(len); qc_src.push_back(src); qc_dst.push_back(dst);
        end
        if (m_cqt == depth - 1) begin
            m_cqt = 0; m_phase = ~m_phase;
        end else begin
            m_cqt++;
        end
        sq_tail = IDX_W'(sw_tail);
    endtask

    // monitor: memory traffic and interrupt, every clock
    int a, slot, k;
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                chk(irq == irq_next, "R11 irq pulse", 64'(irq), 64'(irq_next));
                irq_next = 1'b0;
                if (mem_req && !mem_we) begin
                    slot = (int'(mem_addr) - SQB) / 8;
                    chk(q_sqslot.size() > 0 && slot == q_sqslot[0], "R3/R12 fetch slot",
                        64'(slot), q_sqslot.size() > 0 ? 64'(q_sqslot[0]) : 64'hFFFF);
                end
                if (mem_req && mem_we) begin
                    a = int'(mem_addr) - CQB; slot = a / 4; k = a % 4;
                    if (q_slot.size() == 0) begin
                        chk(1'b0, "R12 unexpected completion write", 64'(mem_addr), 64'h0);
                    end else begin
                        chk(slot == q_slot[0], "R7/R9 completion slot", 64'(slot), 64'(q_slot[0]));
                        chk(((slot + 1) % depth) != sw_cqh, "R10 write while full", 64'(slot), 64'(sw_cqh));
                        if (k == 2)
                            chk(mem_wdata == q_w2[0], "R7 head word", 64'(mem_wdata), 64'(q_w2[0]));
                        else if (k == 3)
                            chk(mem_wdata == q_w3[0], "R5/R6/R7/R8 status word", 64'(mem_wdata), 64'(q_w3[0]));
                        else
                            chk(mem_wdata == 32'h0, "R7 reserved word", 64'(mem_wdata), 64'h0);
                        if (k == 3) begin
                            irq_next = q_irq[0];
                            void'(q_slot.pop_front()); void'(q_sqslot.pop_front());
                            void'(q_w2.pop_front()); void'(q_w3.pop_front()); void'(q_irq.pop_front());
                        end
                    end
                    wr_cnt++;
                end
            end
        end
    end

    // data mover responder
    int wait_n = 0;
    initial begin
        copy_done = 1'b0;
        forever begin
            @(negedge clk); #1;
            if (copy_done) begin
                copy_done = 1'b0;
            end else if (copy_req && rst_n) begin
                if (wait_n == 0) begin
                    if (qc_len.size() == 0) begin
                        chk(1'b0, "R5/R6 copy for non-copy opcode", 64'(copy_len), 64'h0);
                    end else begin
                        chk(copy_len == qc_len[0], "R4 copy length", 64'(copy_len), 64'(qc_len[0]));
                        chk(copy_src == qc_src[0], "R4 copy source", copy_src, qc_src[0]);
                        chk(copy_dst == qc_dst[0], "R4 copy destination", copy_dst, qc_dst[0]);
                        void'(qc_len.pop_front()); void'(qc_src.pop_front()); void'(qc_dst.pop_front());
                    end
                end
                wait_n++;
                if (wait_n == 3) begin
                    copy_done = 1'b1;
                    wait_n = 0;
                end
            end
        end
    end

    task automatic drain();
        while (q_slot.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    int wc0;
    initial begin
        rst_n = 1'b0;
        wr_cnt = 0;
        model_reset(4);
        repeat (3) @(negedge clk);
        chk(sq_head == 0 && cq_tail == 0, "R1 pointers in reset", 64'({sq_head, cq_tail}), 64'h0);
        chk(!irq && !copy_req && !mem_req, "R1 outputs in reset", 64'({irq, copy_req, mem_req}), 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            chk(!mem_req && !copy_req, "R2 idle when no work", 64'({mem_req, copy_req}), 64'h0);
        end

        // depth 4: copy, small package, unknown opcode
        @(negedge clk);
        submit(4'h4, 1'b1, 32'h0000_0100, 64'h1111_0000_2222_3333, 64'h4444_5555_6666_7770);
        submit(4'h1, 1'b0, 32'h0000_0040, 64'h0, 64'h0);
        submit(4'h7, 1'b1, 32'h0000_0010, 64'h9, 64'hA);
        drain();
        chk(cq_tail == 3, "R9 completion tail", 64'(cq_tail), 64'd3);
        chk(sq_head == 3, "R12 submission head", 64'(sq_head), 64'd3);

        // ring full: fourth entry must wait
        submit(4'h4, 1'b0, 32'h0000_0200, 64'hBEEF_0000_0000_1000, 64'hCAFE_0000_0000_2000);
        wc0 = wr_cnt;
        repeat (25) @(negedge clk);
        #1;
        chk(wr_cnt == wc0, "R10 stall while full", 64'(wr_cnt), 64'(wc0));
        chk(cq_tail == 3, "R10 tail held while full", 64'(cq_tail), 64'd3);
        chk(sq_head == 0, "R9 submission head wrap", 64'(sq_head), 64'd0);
        @(negedge clk);
        sw_cqh = 2; cq_head = 2;
        drain();
        chk(cq_tail == 0, "R8/R9 completion tail wrap", 64'(cq_tail), 64'd0);

        // after the wrap the valid bit reads 0
        submit(4'h4, 1'b1, 32'h0000_0008, 64'h0000_0001_0000_0004, 64'h0000_0002_0000_0008);
        drain();
        chk(cq_tail == 1, "R9 tail after wrap", 64'(cq_tail), 64'd1);

        // depth 8 after a fresh reset
        rst_n = 1'b0;
        model_reset(8);
        repeat (2) @(negedge clk);
        chk(sq_head == 0 && cq_tail == 0, "R1 pointers after reset", 64'({sq_head, cq_tail}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        submit(4'h4, 1'b1, 32'h11, 64'h100, 64'h200);
        submit(4'h4, 1'b0, 32'h22, 64'h300, 64'h400);
        submit(4'hF, 1'b1, 32'h33, 64'h500, 64'h600);
        submit(4'h1, 1'b1, 32'h44, 64'h700, 64'h800);
        submit(4'h4, 1'b1, 32'h55, 64'hFFFF_FFFF_0000_0900, 64'h8000_0000_0000_0A00);
        drain();
        chk(sq_head == 5 && cq_tail == 5, "R12 burst order", 64'({sq_head, cq_tail}), 64'h55);
        sw_cqh = 5; cq_head = 5;
        submit(4'h4, 1'b0, 32'h66, 64'hB00, 64'hC00);
        submit(4'h4, 1'b1, 32'h77, 64'hD00, 64'hE00);
        submit(4'h2, 1'b0, 32'h88, 64'hF00, 64'h1000);
        submit(4'h4, 1'b1, 32'h99, 64'h1100, 64'h1200);
        drain();
        chk(sq_head == 1 && cq_tail == 1, "R8/R9 wrap at depth 8", 64'({sq_head, cq_tail}), 64'h11);
        chk(qc_len.size() == 0, "R4 all copies issued", 64'(qc_len.size()), 64'h0);
        finish_run();
    end
endmodule